// File: doc/BRIEF.md
# Interrupt Message Ring Writer

This block sits between the fabric that delivers message-signalled interrupts and system memory. Every incoming interrupt message carries one 32-bit data word. The block wraps that word into a 16-byte record and writes the record into a circular queue in memory. The queue starts at a programmable 64-bit base address, and its size is one of four powers of two. The block owns the producer offset. Software consumes records, then moves the consumer offset forward through a small word-addressed register bank.

A level interrupt tells software that unread records are waiting. Optional full detection guards the queue against overrun. When the queue is full, the block either back-pressures the message source or drops the message and sets a sticky overflow flag. Only one memory write is in flight at any time. The producer offset moves only when memory accepts the write.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `msg_ready` is low, `mem_req_valid` is low and `irq_out` is low.
- R2: The settings register sits at word 0. Its writable fields are: run at bit 0, full-detect at bit 1, interrupt-enable at bit 3, stall-on-full at bit 4 and a size code at bits 9:8. Writing all ones reads back 0x31B. The base address upper half sits at word 3 and the lower half at word 4, and both read back as written. Unused words read zero.
- R3: Each record write has address = {base upper, base lower} + producer offset. Data bits 31:0 hold the message word (byte 0 of the record is its least significant byte), and data bits 127:32 are zero.
- R4: The producer offset, readable at word 6, advances by 16 only in the cycle memory accepts a write. While `mem_req_valid` is high and `mem_req_ready` is low, the request address and data hold steady.
- R5: Offsets wrap modulo a queue size of 2^(15+code) bytes, where code is the size field (32 KB to 256 KB).
- R6: A write to the consumer offset at word 5 is stored masked to the current queue size with bits 3:0 cleared. It reads back masked.
- R7: `irq_out` is high exactly when interrupt-enable is set and the consumer offset differs from the producer offset.
- R8: The queue is full when full-detect is set and (producer + 16) mod size equals the consumer offset. If stall-on-full is also set, `msg_ready` is low while the queue is full.
- R9: When the queue is full and stall-on-full is clear, a message is accepted and discarded with no memory write. This sets a sticky overflow flag at settings bit 16. Only a settings write with bit 16 set clears the flag.
- R10: With the run bit clear, `msg_ready` stays low and no memory write starts.
- R11: With full-detect clear, records keep being written even when the producer offset reaches or passes the consumer offset.
- R12: While a record write is outstanding, `msg_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cb_we | input | 1 | Register write strobe |
| cb_addr | input | 3 | Register word address |
| cb_wdata | input | 32 | Register write data |
| cb_rdata | output | 32 | Register read data (combinational from cb_addr) |
| msg_valid | input | 1 | Interrupt message present |
| msg_data | input | 32 | Interrupt message data word |
| msg_ready | output | 1 | Message accepted when high together with msg_valid |
| mem_req_valid | output | 1 | Record write request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Record byte address |
| mem_req_data | output | 128 | Record payload |
| irq_out | output | 1 | Level interrupt: unread records present |

## Verification
The assertions assume that memory may hold off `mem_req_ready` for any number of cycles. They also assume that software does not change the size code while a record write is outstanding, because the producer offset reads back masked by that code. The bench changes the size only between messages, when no write is pending. It drives `mem_req_ready` with a repeating stall pattern, and one phase holds it low for a long time. The base address is kept 16-byte aligned, so record addresses stay aligned to records.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    localparam int CB_AW     = 3;
    localparam int CB_DW     = 32;
    localparam int MSG_W     = 32;
    localparam int MEM_AW    = 64;
    localparam int MEM_DW    = 128;
    localparam int REC_BYTES = 16;
    localparam int SZ_W      = 2;
    localparam int MIN_SHIFT = 15;
    localparam int OFF_W     = MIN_SHIFT + (1 << SZ_W) - 1;

    localparam logic [CB_AW-1:0] REG_CTRL    = 3'd0;
    localparam logic [CB_AW-1:0] REG_BASE_HI = 3'd3;
    localparam logic [CB_AW-1:0] REG_BASE_LO = 3'd4;
    localparam logic [CB_AW-1:0] REG_CONS    = 3'd5;
    localparam logic [CB_AW-1:0] REG_PROD    = 3'd6;

    localparam int B_RUN   = 0;
    localparam int B_FDET  = 1;
    localparam int B_IRQ   = 3;
    localparam int B_STALL = 4;
    localparam int B_SZ    = 8;
    localparam int B_OVF   = 16;

    localparam logic [SZ_W-1:0] SZ_MAX = '1;

    typedef struct packed {
        logic [SZ_W-1:0] size_code;
        logic            stall_full;
        logic            irq_en;
        logic            full_det;
        logic            run;
    } ctrl_t;

    typedef struct packed {
        logic [MEM_AW-1:0] addr;
        logic [MEM_DW-1:0] data;
    } rec_req_t;

    function automatic logic [OFF_W-1:0] off_mask(input logic [SZ_W-1:0] code);
        logic [OFF_W-1:0] m;
        m = {OFF_W{1'b1}} >> (SZ_MAX - code);
        return m & ~OFF_W'(REC_BYTES - 1);
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [CB_DW-1:0] w);
        ctrl_t c;
        c.run        = w[B_RUN];
        c.full_det   = w[B_FDET];
        c.irq_en     = w[B_IRQ];
        c.stall_full = w[B_STALL];
        c.size_code  = w[B_SZ +: SZ_W];
        return c;
    endfunction

    function automatic logic [CB_DW-1:0] ctrl_to_word(input ctrl_t c, input logic ovf);
        logic [CB_DW-1:0] w;
        w               = '0;
        w[B_RUN]        = c.run;
        w[B_FDET]       = c.full_det;
        w[B_IRQ]        = c.irq_en;
        w[B_STALL]      = c.stall_full;
        w[B_SZ +: SZ_W] = c.size_code;
        w[B_OVF]        = ovf;
        return w;
    endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cb_we,
    input  logic [CB_AW-1:0]    cb_addr,
    input  logic [CB_DW-1:0]    cb_wdata,
    output logic [CB_DW-1:0]    cb_rdata,
    input  logic                ovf_set,
    input  logic [OFF_W-1:0]    prod_off,
    output ctrl_t               ctrl,
    output logic [MEM_AW-1:0]   base,
    output logic [OFF_W-1:0]    cons_off
);

    ctrl_t              ctrl_q;
    logic [CB_DW-1:0]   base_hi_q;
    logic [CB_DW-1:0]   base_lo_q;
    logic [OFF_W-1:0]   cons_q;
    logic               ovf_q;
    logic               wr_ctrl;

    assign wr_ctrl = cb_we && (cb_addr == REG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            base_hi_q <= '0;
            base_lo_q <= '0;
            cons_q    <= '0;
        end else if (cb_we) begin
            case (cb_addr)
                REG_CTRL:    ctrl_q    <= ctrl_from_word(cb_wdata);
                REG_BASE_HI: base_hi_q <= cb_wdata;
                REG_BASE_LO: base_lo_q <= cb_wdata;
                REG_CONS:    cons_q    <= cb_wdata[OFF_W-1:0] & off_mask(ctrl_q.size_code);
                default:     ;
            endcase
        end
    end

    // sticky overflow: a new drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (ovf_set)
            ovf_q <= 1'b1;
        else if (wr_ctrl && cb_wdata[B_OVF])
            ovf_q <= 1'b0;
    end

    always_comb begin
        case (cb_addr)
            REG_CTRL:    cb_rdata = ctrl_to_word(ctrl_q, ovf_q);
            REG_BASE_HI: cb_rdata = base_hi_q;
            REG_BASE_LO: cb_rdata = base_lo_q;
            REG_CONS:    cb_rdata = CB_DW'(cons_q & off_mask(ctrl_q.size_code));
            REG_PROD:    cb_rdata = CB_DW'(prod_off);
            default:     cb_rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign base     = {base_hi_q, base_lo_q};
    assign cons_off = cons_q;

endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [OFF_W-1:0]  cons_off,
    input  logic              advance,
    output logic [OFF_W-1:0]  prod_off,
    output logic              full,
    output logic              nonempty
);

    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] prod_q;
    logic [OFF_W-1:0] prod_m;
    logic [OFF_W-1:0] cons_m;
    logic [OFF_W-1:0] prod_next;

    assign mask      = off_mask(ctrl.size_code);
    assign prod_m    = prod_q & mask;
    assign cons_m    = cons_off & mask;
    assign prod_next = (prod_m + OFF_W'(REC_BYTES)) & mask;

    always_ff @(posedge clk) begin
        if (rst)
            prod_q <= '0;
        else if (advance)
            prod_q <= prod_next;
    end

    assign prod_off = prod_m;
    assign full     = ctrl.full_det && (prod_next == cons_m);
    assign nonempty = (prod_m != cons_m);

endmodule

// File: rtl/msi_ring_issue.sv
module msi_ring_issue
    import msi_ring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               full,
    input  logic [MEM_AW-1:0]  base,
    input  logic [OFF_W-1:0]   prod_off,
    input  logic               msg_valid,
    input  logic [MSG_W-1:0]   msg_data,
    output logic               msg_ready,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MEM_AW-1:0]  mem_req_addr,
    output logic [MEM_DW-1:0]  mem_req_data,
    output logic               advance,
    output logic               ovf_set
);

    logic      pend_q;
    rec_req_t  req_q;
    logic      take;
    logic      store;

    assign msg_ready = ctrl.run && !pend_q && !(full && ctrl.stall_full);
    assign take      = msg_valid && msg_ready;
    assign store     = take && !full;
    assign ovf_set   = take && full;
    assign advance   = pend_q && mem_req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            req_q  <= '0;
        end else begin
            if (store) begin
                pend_q     <= 1'b1;
                req_q.addr <= base + {{(MEM_AW-OFF_W){1'b0}}, prod_off};
                req_q.data <= {{(MEM_DW-MSG_W){1'b0}}, msg_data};
            end else if (advance) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign mem_req_valid = pend_q;
    assign mem_req_addr  = req_q.addr;
    assign mem_req_data  = req_q.data;

endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
    import msi_ring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cb_we,
    input  logic [CB_AW-1:0]   cb_addr,
    input  logic [CB_DW-1:0]   cb_wdata,
    output logic [CB_DW-1:0]   cb_rdata,
    input  logic               msg_valid,
    input  logic [MSG_W-1:0]   msg_data,
    output logic               msg_ready,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MEM_AW-1:0]  mem_req_addr,
    output logic [MEM_DW-1:0]  mem_req_data,
    output logic               irq_out
);

    ctrl_t              ctrl_w;
    logic [MEM_AW-1:0]  base_w;
    logic [OFF_W-1:0]   cons_w;
    logic [OFF_W-1:0]   prod_w;
    logic               full_w;
    logic               nonempty_w;
    logic               advance_w;
    logic               ovf_set_w;

    msi_ring_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cb_we    (cb_we),
        .cb_addr  (cb_addr),
        .cb_wdata (cb_wdata),
        .cb_rdata (cb_rdata),
        .ovf_set  (ovf_set_w),
        .prod_off (prod_w),
        .ctrl     (ctrl_w),
        .base     (base_w),
        .cons_off (cons_w)
    );

    msi_ring_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_w),
        .cons_off (cons_w),
        .advance  (advance_w),
        .prod_off (prod_w),
        .full     (full_w),
        .nonempty (nonempty_w)
    );

    msi_ring_issue u_issue (
        .clk           (clk),
        .rst           (rst),
        .ctrl          (ctrl_w),
        .full          (full_w),
        .base          (base_w),
        .prod_off      (prod_w),
        .msg_valid     (msg_valid),
        .msg_data      (msg_data),
        .msg_ready     (msg_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .advance       (advance_w),
        .ovf_set       (ovf_set_w)
    );

    assign irq_out = ctrl_w.irq_en && nonempty_w;

endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk
    import msi_ring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_ready,
    input  logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic [MEM_AW-1:0]  mem_req_addr,
    input  logic [MEM_DW-1:0]  mem_req_data,
    input  logic               irq_out,
    input  ctrl_t              ctrl,
    input  logic [OFF_W-1:0]   cons_off,
    input  logic [OFF_W-1:0]   prod_off
);

    logic [OFF_W-1:0] m;
    assign m = off_mask(ctrl.size_code);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data))); // R4
    AST_PROD_STILL: assert property (@(posedge clk) disable iff (rst)
        (!(mem_req_valid && mem_req_ready) ##1 $stable(ctrl.size_code)) |-> $stable(prod_off)); // R4
    AST_REC_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_data[MEM_DW-1:MSG_W] == '0)); // R3
    AST_CONS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cons_off[3:0] == 4'h0); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq_out); // R7
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (prod_off == (cons_off & m)) |-> !irq_out); // R7
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (ctrl.full_det && ctrl.stall_full &&
         (((prod_off + OFF_W'(REC_BYTES)) & m) == (cons_off & m))) |-> !msg_ready); // R8
    AST_HALTED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !msg_ready); // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !msg_ready); // R12

endmodule

bind msi_ring_writer msi_ring_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .msg_ready     (msg_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .irq_out       (irq_out),
    .ctrl          (ctrl_w),
    .cons_off      (cons_w),
    .prod_off      (prod_w)
);

// File: tb/sim_msi_ring_writer.sv
module sim_msi_ring_writer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cb_we = 1'b0;
    logic [2:0]   cb_addr = '0;
    logic [31:0]  cb_wdata = '0;
    logic [31:0]  cb_rdata;
    logic         msg_valid = 1'b0;
    logic [31:0]  msg_data = '0;
    logic         msg_ready;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic [127:0] mem_req_data;
    logic         irq_out;

    always #4 clk = ~clk;

    msi_ring_writer u0 (
        .clk(clk), .rst(rst), .cb_we(cb_we), .cb_addr(cb_addr),
        .cb_wdata(cb_wdata), .cb_rdata(cb_rdata), .msg_valid(msg_valid),
        .msg_data(msg_data), .msg_ready(msg_ready), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    localparam logic [63:0] BASE = 64'h0000_00A5_1234_0000;
    int          size_code = 0;
    logic [31:0] exp_prod = '0;

    function automatic logic [31:0] bmask(input int code);
        return ((32'h8000 << code) - 32'd1) & ~32'hF;
    endfunction

    // memory side model: stall pattern plus record capture
    int           cyc = 0;
    bit           hold_mem = 0;
    bit           mon_expect = 0;
    logic [63:0]  mon_addr = '0;
    logic [127:0] mon_data = '0;
    string        mon_tag = "R3";
    int           log_cnt = 0;

    always @(negedge clk) begin
        cyc++;
        mem_req_ready = !hold_mem && ((cyc % 3) != 1);
        #1;
        if (!rst && mem_req_valid && mem_req_ready) begin
            log_cnt++;
            check(mon_expect, {mon_tag, " unexpected record write"}, 1, 0);
            check(mem_req_addr == mon_addr, {mon_tag, " record address"}, mem_req_addr, mon_addr);
            check(mem_req_data == mon_data, {mon_tag, " record payload"}, mem_req_data, mon_data);
            mon_expect = 0;
        end
    end

    task automatic cb_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cb_we = 1'b1; cb_addr = a; cb_wdata = d;
        @(negedge clk);
        cb_we = 1'b0;
        if (a == 3'd0) size_code = int'(d[9:8]);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        cb_addr = a;
        #1;
        v = cb_rdata;
    endtask

    task automatic send_msg(input logic [31:0] d, input bit expect_wr, input string tag);
        int g;
        int c0;
        c0 = log_cnt;
        mon_tag = tag;
        mon_addr = BASE + {32'h0, exp_prod};
        mon_data = {96'h0, d};
        mon_expect = expect_wr;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d;
        g = 0;
        while (g < 60) begin
            #1;
            if (msg_ready) break;
            @(negedge clk);
            g++;
        end
        check(g < 60, {tag, " message never accepted"}, g, 0);
        @(negedge clk);
        msg_valid = 1'b0;
        if (expect_wr) begin
            g = 0;
            while (log_cnt == c0 && g < 60) begin
                @(negedge clk);
                g++;
            end
            check(log_cnt == c0 + 1, {tag, " record written"}, log_cnt - c0, 1);
            exp_prod = (exp_prod + 32'd16) & bmask(size_code);
        end else begin
            repeat (3) @(negedge clk);
            check(log_cnt == c0, {tag, " dropped message wrote memory"}, log_cnt - c0, 0);
            mon_expect = 0;
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c0;
        logic [63:0]  sa;
        repeat (3) @(negedge clk);
        // R1: reset state, during and after reset
        check(msg_ready == 0 && mem_req_valid == 0 && irq_out == 0, "R1 outputs in reset", {msg_ready, mem_req_valid, irq_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), v);
            check(v == 0, "R1 register zero", v, 0);
        end
        check(msg_ready == 0 && mem_req_valid == 0 && irq_out == 0, "R1 outputs after reset", {msg_ready, mem_req_valid, irq_out}, 0);

        // R2: register fields
        cb_wr(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, v); check(v == 32'h0000_031B, "R2 settings field mask", v, 32'h31B);
        cb_wr(3'd0, 32'h0001_0000);
        rd_reg(3'd0, v); check(v == 0, "R2 settings cleared", v, 0);
        cb_wr(3'd3, BASE[63:32]);
        cb_wr(3'd4, BASE[31:0]);
        rd_reg(3'd3, v); check(v == BASE[63:32], "R2 base upper", v, BASE[63:32]);
        rd_reg(3'd4, v); check(v == BASE[31:0], "R2 base lower", v, BASE[31:0]);
        rd_reg(3'd1, v); check(v == 0, "R2 unused word", v, 0);
        rd_reg(3'd7, v); check(v == 0, "R2 unused word", v, 0);

        // R6: consumer offset masking for every size code
        for (int c = 0; c < 4; c++) begin
            cb_wr(3'd0, 32'(c) << 8);
            cb_wr(3'd5, 32'hFFFF_FFFF);
            rd_reg(3'd5, v); check(v == bmask(c), "R6 consumer offset masked", v, bmask(c));
            cb_wr(3'd5, 32'h0000_1237);
            rd_reg(3'd5, v); check(v == 32'h1230, "R6 consumer offset aligned", v, 32'h1230);
        end
        cb_wr(3'd5, 32'h0);

        // R10: halted block ignores messages
        cb_wr(3'd0, 32'h0000_0018);
        c0 = log_cnt;
        @(negedge clk); msg_valid = 1'b1; msg_data = 32'hDEAD_BEEF;
        for (int i = 0; i < 5; i++) begin
            #1; check(msg_ready == 0, "R10 ready while halted", msg_ready, 0);
            @(negedge clk);
        end
        msg_valid = 1'b0;
        check(log_cnt == c0, "R10 no write while halted", log_cnt - c0, 0);
        rd_reg(3'd6, v); check(v == 0, "R10 producer unchanged", v, 0);

        // R3/R4: main flow with stalls, size code 0
        cb_wr(3'd0, 32'h0000_000B);
        for (int i = 0; i < 8; i++) send_msg(32'hA000_0000 + 32'(i) * 32'h0101_0101, 1, "R3");
        rd_reg(3'd6, v); check(v == 32'd128, "R4 producer after 8 records", v, 128);

        // R7: interrupt level
        #1; check(irq_out == 1, "R7 irq with unread records", irq_out, 1);
        cb_wr(3'd0, 32'h0000_0003);
        #1; check(irq_out == 0, "R7 irq disabled", irq_out, 0);
        cb_wr(3'd0, 32'h0000_000B);
        cb_wr(3'd5, 32'd128);
        #1; check(irq_out == 0, "R7 irq when drained", irq_out, 0);
        cb_wr(3'd5, 32'd112);
        #1; check(irq_out == 1, "R7 irq when one record unread", irq_out, 1);

        // R12/R4: long memory stall
        cb_wr(3'd5, exp_prod);
        hold_mem = 1;
        mon_tag = "R4"; mon_addr = BASE + {32'h0, exp_prod};
        mon_data = {96'h0, 32'h5555_AAAA}; mon_expect = 1;
        c0 = log_cnt;
        @(negedge clk); msg_valid = 1'b1; msg_data = 32'h5555_AAAA;
        @(negedge clk); msg_valid = 1'b0;
        sa = mem_req_addr;
        for (int i = 0; i < 6; i++) begin
            #1;
            check(mem_req_valid == 1, "R4 request held", mem_req_valid, 1);
            check(mem_req_addr == sa, "R4 address stable", mem_req_addr, sa);
            check(msg_ready == 0, "R12 ready low while outstanding", msg_ready, 0);
            rd_reg(3'd6, v); check(v == exp_prod, "R4 producer waits for accept", v, exp_prod);
            @(negedge clk);
        end
        hold_mem = 0;
        while (log_cnt == c0) @(negedge clk);
        exp_prod = (exp_prod + 32'd16) & bmask(size_code);
        rd_reg(3'd6, v); check(v == exp_prod, "R4 producer after accept", v, exp_prod);

        // R8: stall on full
        cb_wr(3'd0, 32'h0000_0013);
        cb_wr(3'd5, (exp_prod + 32'd32) & bmask(0));
        send_msg(32'h1111_0001, 1, "R8");
        c0 = log_cnt;
        @(negedge clk); msg_valid = 1'b1; msg_data = 32'h1111_0002;
        for (int i = 0; i < 5; i++) begin
            #1; check(msg_ready == 0, "R8 ready low when full", msg_ready, 0);
            @(negedge clk);
        end
        msg_valid = 1'b0;
        check(log_cnt == c0, "R8 no write when full", log_cnt - c0, 0);
        cb_wr(3'd5, (exp_prod + 32'd32) & bmask(0));
        #1; check(msg_ready == 1, "R8 ready after consumer moves", msg_ready, 1);

        // R9: drop on full with sticky overflow
        cb_wr(3'd0, 32'h0000_0003);
        send_msg(32'h2222_0001, 1, "R9");
        rd_reg(3'd0, v); check(v == 32'h3, "R9 no overflow yet", v, 32'h3);
        send_msg(32'h2222_0002, 0, "R9");
        rd_reg(3'd0, v); check(v == 32'h0001_0003, "R9 overflow set", v, 32'h10003);
        rd_reg(3'd6, v); check(v == exp_prod, "R9 producer unchanged on drop", v, exp_prod);
        cb_wr(3'd0, 32'h0000_0003);
        rd_reg(3'd0, v); check(v == 32'h0001_0003, "R9 overflow sticky", v, 32'h10003);
        cb_wr(3'd0, 32'h0001_0003);
        rd_reg(3'd0, v); check(v == 32'h0000_0003, "R9 overflow cleared", v, 32'h3);

        // R11: full detection off writes through the full point
        cb_wr(3'd0, 32'h0000_0001);
        send_msg(32'h3333_0001, 1, "R11");
        send_msg(32'h3333_0002, 1, "R11");
        rd_reg(3'd6, v); check(v == exp_prod, "R11 producer passed consumer", v, exp_prod);

        // R5: wrap sweeps over sizes 32 KB and 64 KB, then 256 KB
        cb_wr(3'd0, 32'h0000_0009);
        for (int i = 0; i < 2050; i++) send_msg(32'h0005_0000 + 32'(i), 1, "R5");
        rd_reg(3'd6, v); check(v == exp_prod, "R5 producer after 32 KB sweep", v, exp_prod);
        cb_wr(3'd0, 32'h0000_0109);
        for (int i = 0; i < 4100; i++) send_msg(32'h0006_0000 + 32'(i), 1, "R5");
        rd_reg(3'd6, v); check(v == exp_prod, "R5 producer after 64 KB sweep", v, exp_prod);
        cb_wr(3'd0, 32'h0000_0309);
        for (int i = 0; i < 20; i++) send_msg(32'h0007_0000 + 32'(i), 1, "R5");
        rd_reg(3'd6, v); check(v == exp_prod, "R5 producer at 256 KB", v, exp_prod);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule